// File: doc/BRIEF.md
# 64-bit SECDED Check-Byte Unit

This block protects a 64-bit memory word with an 8-bit check byte built from a fixed, irregular parity-check matrix. Each check bit is the parity of a selected subset of the data bits. The subset is given by a pair of 32-bit masks, one over the upper half of the word and one over the lower half. In encode mode the block returns the check byte for a data word, ready to be stored alongside it.

In check mode the block takes a captured data word and its captured check byte. It recomputes the check byte and XORs it with the captured one to form a syndrome, then classifies the result. If the syndrome equals the matrix column of a data bit, that data bit is reported and corrected. If it matches no data column and has exactly one bit set, the corresponding check bit is reported. A zero syndrome means no error. Any other syndrome is uncorrectable. When the attached memory bus runs at half width, the block detects errors but does not locate them. Results appear on registered outputs one clock after a valid input.

Top module: `secded_check_unit`

## Requirements
- R1: Check bit k (k = 7 down to 0) of the byte on `outCheck` is the XOR of the data bits selected by its upper-half and lower-half masks, which are, from k = 7 down to k = 0: f00fe11e/c33c0ff7, 00ff00ff/00fff0ff, 0f0f0f0f/0f0fff00, 11113333/7777000f, 22224444/8888222f, 44448888/ffff4441, 8888ffff/11118882, ffff1111/22221114. Mask bit j of the upper mask selects data bit 32+j, and mask bit j of the lower mask selects data bit j.
- R2: When `inValid` is high at a rising edge, `outValid` is high after that edge and all result outputs reflect that input. When `inValid` is low, `outValid` is low after the edge.
- R3: In check mode (`inMode` = 1), `outSyndrome` equals the recomputed check byte XOR `inCheck`.
- R4: In check mode with `narrowBus` = 0, if the syndrome equals the column of data bit b, `outStatus` = 1, `outDataBit` = b, and `outData` is the input with bit b inverted. The column of bit b has as its bit k the bit (b mod 32) of the lower mask of check bit k when b < 32, or of the upper mask when b ≥ 32. When several columns match, the lowest b is chosen.
- R5: In check mode with `narrowBus` = 0, if no data column matches and exactly one syndrome bit j is set, `outStatus` = 2, `outCheckBit` = j, `outDataBit` = 8'hFF, and `outData` equals the input.
- R6: In check mode, a zero syndrome gives `outStatus` = 0, both index outputs 8'hFF (meaning none), and `outData` equal to the input.
- R7: In check mode with `narrowBus` = 0, a nonzero syndrome that matches no data column and has two or more bits set gives `outStatus` = 3, both indices 8'hFF, and unchanged data.
- R8: In check mode with `narrowBus` = 1, any nonzero syndrome gives `outStatus` = 3 with both indices 8'hFF and unchanged data. No single-bit location is attempted.
- R9: In encode mode (`inMode` = 0), `outStatus` = 0, `outSyndrome` = 0, both indices are 8'hFF, and `outData` equals the input.
- R10: While `rstN` is low, `outValid`, `outData`, `outCheck`, `outSyndrome` and `outStatus` are zero, and both indices are 8'hFF.
- R11: After a cycle with `inValid` low, all result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input word qualifier |
| inMode | input | 1 | 0 = encode, 1 = check |
| narrowBus | input | 1 | 1 = half-width bus, no single-bit location |
| inData | input | 64 | Data word |
| inCheck | input | 8 | Captured check byte (check mode) |
| outValid | output | 1 | Result qualifier, one cycle after input |
| outData | output | 64 | Data word, corrected when status is 1 |
| outCheck | output | 8 | Check byte recomputed from inData |
| outSyndrome | output | 8 | Syndrome (0 in encode mode) |
| outStatus | output | 2 | 0 none, 1 data bit, 2 check bit, 3 uncorrectable |
| outDataBit | output | 8 | Faulty data bit index or 8'hFF |
| outCheckBit | output | 8 | Faulty check bit index or 8'hFF |

## Verification
The bench flips every one of the 64 data bits and every one of the 8 check bits of a codeword. A wrong mask word or a swapped check-bit order would show up as a wrong check byte, a wrong corrected bit, or a data error misread as a check-bit error. Sampled double flips, spread over data and check positions, expose a design that treats any nonzero syndrome as correctable or that flips data on a false column match. Narrow-bus words and idle cycles catch a design that still corrects when it should only detect, or that lets results drift while no input is valid.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int CHK_W  = 8;
  localparam int IDX_W  = 8;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int CPOS_W = $clog2(CHK_W);
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  // Parity masks per check bit, leftmost literal is check bit 7.
  localparam logic [HALF_W-1:0] MASK_HI [CHK_W-1:0] = '{
    32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
    32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111};
  localparam logic [HALF_W-1:0] MASK_LO [CHK_W-1:0] = '{
    32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
    32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114};

  typedef enum logic [1:0] {
    ST_NONE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_CHECK  = 2'd2,
    ST_UNCORR = 2'd3
  } eccStatusT;

  typedef struct packed {
    logic load;
    logic checkMode;
    logic analyse;
  } eccStrobeT;

  // Syndrome pattern produced by a flip of data bit b.
  function automatic logic [CHK_W-1:0] dataColumn(input int b);
    logic [CHK_W-1:0] c;
    for (int k = 0; k < CHK_W; k++) begin
      c[k] = (b < HALF_W) ? MASK_LO[k][b % HALF_W] : MASK_HI[k][b % HALF_W];
    end
    return c;
  endfunction

endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inMode,
  input  logic      narrowBus,
  output eccStrobeT strobe,
  output logic      outValid
);

  always_comb begin
    strobe.load      = inValid;
    strobe.checkMode = inMode;
    strobe.analyse   = inMode & ~narrowBus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobeT         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [CHK_W-1:0]  inCheck,
  output logic [DATA_W-1:0] outData,
  output logic [CHK_W-1:0]  outCheck,
  output logic [CHK_W-1:0]  outSyndrome,
  output eccStatusT         outStatus,
  output logic [IDX_W-1:0]  outDataBit,
  output logic [IDX_W-1:0]  outCheckBit
);

  logic [CHK_W-1:0]  calcChk;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] hit;
  logic              anyHit;
  logic [POS_W-1:0]  hitIdx;
  logic [CPOS_W-1:0] synIdx;

  eccStatusT         nxtStatus;
  logic [DATA_W-1:0] nxtData;
  logic [IDX_W-1:0]  nxtDataBit;
  logic [IDX_W-1:0]  nxtCheckBit;

  // Parity tree per check bit
  for (genvar k = 0; k < CHK_W; k++) begin : g_parity
    assign calcChk[k] = (^(inData[DATA_W-1:HALF_W] & MASK_HI[k]))
                      ^ (^(inData[HALF_W-1:0] & MASK_LO[k]));
  end

  assign syn = strobe.checkMode ? (calcChk ^ inCheck) : '0;

  // One comparator per data column
  for (genvar b = 0; b < DATA_W; b++) begin : g_column
    localparam logic [CHK_W-1:0] COL = dataColumn(b);
    assign hit[b] = (syn == COL);
  end

  // Lowest matching column wins
  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      if (hit[b]) begin
        anyHit = 1'b1;
        hitIdx = POS_W'(b);
      end
    end
  end

  always_comb begin
    synIdx = '0;
    for (int j = CHK_W - 1; j >= 0; j--) begin
      if (syn[j]) synIdx = CPOS_W'(j);
    end
  end

  always_comb begin
    nxtStatus   = ST_NONE;
    nxtData     = inData;
    nxtDataBit  = IDX_NONE;
    nxtCheckBit = IDX_NONE;
    if (strobe.checkMode && (syn != '0)) begin
      if (!strobe.analyse) begin
        nxtStatus = ST_UNCORR;
      end else if (anyHit) begin
        nxtStatus  = ST_DATA;
        nxtDataBit = IDX_W'(hitIdx);
        nxtData    = inData ^ (DATA_W'(1) << hitIdx);
      end else if ($countones(syn) == 1) begin
        nxtStatus   = ST_CHECK;
        nxtCheckBit = IDX_W'(synIdx);
      end else begin
        nxtStatus = ST_UNCORR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData     <= '0;
      outCheck    <= '0;
      outSyndrome <= '0;
      outStatus   <= ST_NONE;
      outDataBit  <= IDX_NONE;
      outCheckBit <= IDX_NONE;
    end else if (strobe.load) begin
      outData     <= nxtData;
      outCheck    <= calcChk;
      outSyndrome <= syn;
      outStatus   <= nxtStatus;
      outDataBit  <= nxtDataBit;
      outCheckBit <= nxtCheckBit;
    end
  end

  // R4: a data correction changes exactly one bit of the captured word
  p_single_fix_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (outStatus != ST_DATA) ||
                    (($countones(outData ^ $past(inData)) == 1) && (outCheckBit == IDX_NONE)));

  // R5: a check-bit report comes with a one-hot syndrome and untouched data
  p_check_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (outStatus != ST_CHECK) ||
                    (($countones(outSyndrome) == 1) && (outData == $past(inData))
                     && (outDataBit == IDX_NONE)));

  // R6: clean result carries no indices and the original word
  p_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (outStatus != ST_NONE) ||
                    ((outDataBit == IDX_NONE) && (outCheckBit == IDX_NONE)
                     && (outData == $past(inData))));

  // R8: half-width bus never yields a located error
  p_narrow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.checkMode && !strobe.analyse) |=>
      ((outStatus == ST_NONE) || (outStatus == ST_UNCORR)));

  // R9: encode mode reports a zero syndrome
  p_encode_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.checkMode) |=> (outSyndrome == '0) && (outStatus == ST_NONE));

  // R11: results hold while idle
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(outData) && $stable(outStatus) && $stable(outSyndrome));

endmodule

// File: rtl/secded_check_unit.sv
module secded_check_unit
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inMode,
  input  logic              narrowBus,
  input  logic [DATA_W-1:0] inData,
  input  logic [CHK_W-1:0]  inCheck,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CHK_W-1:0]  outCheck,
  output logic [CHK_W-1:0]  outSyndrome,
  output logic [1:0]        outStatus,
  output logic [IDX_W-1:0]  outDataBit,
  output logic [IDX_W-1:0]  outCheckBit
);

  eccStrobeT strobe;
  eccStatusT statusQ;

  secded_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMode   (inMode),
    .narrowBus(narrowBus),
    .strobe   (strobe),
    .outValid (outValid)
  );

  secded_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .inCheck    (inCheck),
    .outData    (outData),
    .outCheck   (outCheck),
    .outSyndrome(outSyndrome),
    .outStatus  (statusQ),
    .outDataBit (outDataBit),
    .outCheckBit(outCheckBit)
  );

  assign outStatus = statusQ;

  // R2: result qualifier follows the input qualifier by one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: tb/secded_check_unit_bench.sv
module secded_check_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inMode = 1'b0;
  logic        narrowBus = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inCheck = '0;
  logic        outValid;
  logic [63:0] outData;
  logic [7:0]  outCheck;
  logic [7:0]  outSyndrome;
  logic [1:0]  outStatus;
  logic [7:0]  outDataBit;
  logic [7:0]  outCheckBit;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_check_unit u_secded_check_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .narrowBus(narrowBus), .inData(inData), .inCheck(inCheck),
    .outValid(outValid), .outData(outData), .outCheck(outCheck),
    .outSyndrome(outSyndrome), .outStatus(outStatus),
    .outDataBit(outDataBit), .outCheckBit(outCheckBit));

  // Reference matrix, index 7 first
  logic [31:0] hiM [7:0] = '{32'hf00fe11e, 32'h00ff00ff, 32'h0f0f0f0f, 32'h11113333,
                             32'h22224444, 32'h44448888, 32'h8888ffff, 32'hffff1111};
  logic [31:0] loM [7:0] = '{32'hc33c0ff7, 32'h00fff0ff, 32'h0f0fff00, 32'h7777000f,
                             32'h8888222f, 32'hffff4441, 32'h11118882, 32'h22221114};

  int vecCount = 0;
  int missCount = 0;

  logic        eValid = 1'b0;
  logic [63:0] eData = '0;
  logic [7:0]  eChk = '0;
  logic [7:0]  eSyn = '0;
  logic [1:0]  eStat = '0;
  logic [7:0]  eDBit = 8'hFF;
  logic [7:0]  eCBit = 8'hFF;
  string       eTag = "R10";

  function automatic logic [7:0] refEncode(input logic [63:0] d);
    logic [7:0] r;
    logic p;
    for (int k = 0; k < 8; k++) begin
      p = 1'b0;
      for (int j = 0; j < 32; j++) begin
        if (hiM[k][j]) p = p ^ d[32+j];
        if (loM[k][j]) p = p ^ d[j];
      end
      r[k] = p;
    end
    return r;
  endfunction

  function automatic logic [7:0] refColumn(input int b);
    logic [7:0] c;
    for (int k = 0; k < 8; k++) begin
      if (b < 32) c[k] = loM[k][b];
      else        c[k] = hiM[k][b-32];
    end
    return c;
  endfunction

  task automatic compareNow();
    vecCount++;
    if ({outValid, outData, outCheck, outSyndrome, outStatus, outDataBit, outCheckBit} !==
        {eValid, eData, eChk, eSyn, eStat, eDBit, eCBit}) begin
      missCount++;
      $display("FAIL %s: got v=%0b d=%h c=%h s=%h st=%0d db=%h cb=%h expected v=%0b d=%h c=%h s=%h st=%0d db=%h cb=%h",
               eTag, outValid, outData, outCheck, outSyndrome, outStatus, outDataBit, outCheckBit,
               eValid, eData, eChk, eSyn, eStat, eDBit, eCBit);
    end
  endtask

  task automatic step(input bit v, input bit m, input bit n,
                      input logic [63:0] d, input logic [7:0] c);
    logic [7:0] calc;
    logic [7:0] syn;
    int found;
    @(negedge clk);
    compareNow();
    inValid = v; inMode = m; narrowBus = n; inData = d; inCheck = c;
    if (!v) begin
      eValid = 1'b0;
      eTag = "R11";
    end else begin
      calc = refEncode(d);
      syn = m ? (calc ^ c) : 8'h00;
      eValid = 1'b1; eChk = calc; eSyn = syn; eData = d;
      eStat = 2'd0; eDBit = 8'hFF; eCBit = 8'hFF;
      if (!m) eTag = "R1/R9/R2";
      else if (syn == 8'h00) eTag = "R3/R6/R2";
      else if (n) begin
        eStat = 2'd3; eTag = "R8";
      end else begin
        found = -1;
        for (int b = 63; b >= 0; b--) if (refColumn(b) == syn) found = b;
        if (found >= 0) begin
          eStat = 2'd1; eDBit = 8'(found); eData = d ^ (64'd1 << found); eTag = "R4/R3";
        end else if ($countones(syn) == 1) begin
          eStat = 2'd2; eTag = "R5/R3";
          for (int j = 0; j < 8; j++) if (syn[j]) eCBit = 8'(j);
        end else begin
          eStat = 2'd3; eTag = "R7/R3";
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    missCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    logic [63:0] base;
    logic [7:0]  good;
    logic [71:0] word;
    int p1, p2;
    repeat (3) @(negedge clk);
    // R10: reset values observed while reset is held
    compareNow();
    rstN = 1'b1;

    // R1 / R9: encode several patterns
    step(1, 0, 0, 64'h0, 8'h00);
    step(1, 0, 0, '1, 8'h00);
    step(1, 0, 0, 64'h0123_4567_89ab_cdef, 8'h5a);
    step(1, 0, 0, 64'hdead_beef_0f0f_f0f0, 8'hff);
    for (int i = 0; i < 64; i += 9) step(1, 0, 0, 64'd1 << i, 8'h00);

    // R11: idle cycles hold the last result
    step(0, 1, 0, 64'h5555, 8'h33);
    step(0, 0, 1, 64'h0, 8'h00);

    base = 64'h9e37_79b9_7f4a_7c15;
    good = refEncode(base);
    // R6: clean codeword
    step(1, 1, 0, base, good);
    // R4: every data bit flipped
    for (int b = 0; b < 64; b++) step(1, 1, 0, base ^ (64'd1 << b), good);
    // R5: every check bit flipped
    for (int j = 0; j < 8; j++) step(1, 1, 0, base, good ^ (8'd1 << j));
    // R7: sampled double flips over data and check positions
    for (int i = 0; i < 240; i++) begin
      p1 = (i * 7) % 72;
      p2 = (i * 13 + 5) % 72;
      if (p1 != p2) begin
        word = {good, base ^ {32'(i) * 32'h0101_0101, 32'(i) * 32'h9e37_79b9}};
        good = refEncode(word[63:0]);
        word[71:64] = good;
        word = word ^ (72'd1 << p1) ^ (72'd1 << p2);
        step(1, 1, 0, word[63:0], word[71:64]);
        if (i % 50 == 0) step(0, 0, 0, 64'h0, 8'h00);
      end
    end
    good = refEncode(base);
    // R8: half-width bus detects but does not locate
    step(1, 1, 1, base, good);
    step(1, 1, 1, base ^ 64'h8000, good);
    step(1, 1, 1, base, good ^ 8'h04);
    step(1, 1, 1, base ^ 64'h3, good);
    step(0, 1, 0, 64'h0, 8'h00);
    step(0, 0, 0, 64'h0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule